// File: doc/BRIEF.md
# Banked GPIO Controller with Half-Bank Masked Writes

This block is a register-mapped general-purpose I/O controller. Its pins are split into banks of up to 32 pins, and each bank can be shorter than 32. A 32-bit register port gives software access to each bank's registers: pin direction, output enable, the incoming pin levels, and a set of interrupt controls. Each pad is modelled as a driven value plus an enable, and a separate input per pin carries the pad level back in.

Software changes output pins only through two masked-write registers per bank. One covers pins 0 to 15 and the other covers pins 16 to 31. Bits 31:16 of the written word hold a mask and bits 15:0 hold the new levels. Every pin whose mask bit is clear takes its data bit in that single write. Pins whose mask bit is set keep their level. No read-modify-write is needed, so two agents can own different pins of the same bank without a race.

Incoming levels pass through a two-stage synchronizer. The synchronized level is what software reads back, and it also feeds the interrupt detector. For each pin the detector can be set to level or edge mode, to either polarity, or to trigger on both edges. A single level-sensitive interrupt output is the OR of all status bits that are not masked. The bank layout is a parameter: the default is four banks of 32, 22, 32 and 32 pins, and a six-bank layout of 26, 26, 26, 32, 32 and 32 pins is also supported.

Top module: `pinbank_ctrl`

## Requirements
- R1: While rst_n is low, and right after it rises, pad_out, pad_oe and irq are all 0. Direction, output enable, status, type, polarity and any-edge read as 0. The mask reads as all ones over the pins that exist, so every interrupt starts masked.
- R2: A write to byte address 8*b changes pins 0..15 of bank b. For each i below 16, pin i takes data bit i when mask bit 16+i is 0, and keeps its level when mask bit 16+i is 1. If reg_we is low, pad_out does not change.
- R3: A write to byte address 8*b+4 works the same way on pins 16..31 of bank b: bit i of the data and bit 16+i of the mask control pin 16+i.
- R4: Bank b has a direction register at 0x204+0x40*b, where 1 means output, and an output-enable register at 0x208+0x40*b. pad_oe for a pin is 1 only when both bits are 1. pad_oe changes only after a write.
- R5: Byte address 0x060+4*b reads the synchronized pad level of bank b, with bit n for pin n. A change on pad_in shows there after the second rising clock edge.
- R6: Bit positions of pins that do not exist in a short bank read as 0 in every register, and writes to them have no effect on pad_out, pad_oe or any readback.
- R7: Writing 1s to the enable register (0x210+0x40*b) clears those mask bits. Writing 1s to the disable register (0x214+0x40*b) sets them, so writing 0xFFFFFFFF masks the whole bank. The mask reads back at 0x20C+0x40*b.
- R8: In edge mode (type bit 1 at 0x21C+0x40*b), a status bit is set on a rising synchronized edge when polarity (0x220+0x40*b) is 1, and on a falling edge when polarity is 0. When the any-edge bit (0x224+0x40*b) is 1, both edges set it. The bit is set on the third rising clock edge after the pad changes.
- R9: In level mode (type bit 0), the status bit is set on every cycle in which the synchronized level equals the polarity bit.
- R10: Status (0x218+0x40*b) is cleared by writing 1s to it. If a clear and a new detection happen in the same cycle, the status bit stays set.
- R11: irq is 1 exactly when some bank has a status bit set whose mask bit is 0.
- R12: Direction, output enable, type, polarity and any-edge read back the value last written. The masked-write, enable and disable addresses, and any unmapped address, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pad_in | input | 32*NUM_BANKS | Pad levels, 32 bits per bank |
| pad_out | output | 32*NUM_BANKS | Output level per pin |
| pad_oe | output | 32*NUM_BANKS | Drive enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume three things about the inputs. Addresses are word-aligned. rst_n is released away from a clock edge. reg_we is only asserted while the address and data are stable for the whole cycle. The pad-output stability checks rely on this, because they treat a cycle without reg_we as one in which no pin can move.

The bench keeps within these limits. It changes reg_addr, reg_wdata, reg_we and pad_in only on the falling clock edge, always uses aligned addresses, and releases reset between edges. It moves the pad inputs only on pins whose interrupt configuration was set up beforehand, so every expected status bit follows from the synchronizer delay stated in R5 and R8.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int PIN_W   = 32;
  localparam int HALF_W  = 16;
  localparam int FIELD_W = 6;

  // address map: half-bank writes, pin readback, control window
  localparam int MW_STRIDE   = 8;
  localparam int IN_BASE     = 'h060;
  localparam int IN_STRIDE   = 4;
  localparam int CTRL_BASE   = 'h200;
  localparam int CTRL_STRIDE = 'h40;
  localparam int OFS_DIR  = 'h04;
  localparam int OFS_OE   = 'h08;
  localparam int OFS_MSK  = 'h0C;
  localparam int OFS_IEN  = 'h10;
  localparam int OFS_IDIS = 'h14;
  localparam int OFS_STS  = 'h18;
  localparam int OFS_TYP  = 'h1C;
  localparam int OFS_POL  = 'h20;
  localparam int OFS_ANY  = 'h24;

  typedef struct packed {
    logic lo;
    logic hi;
    logic dir;
    logic oe;
    logic ien;
    logic idis;
    logic sts;
    logic typ;
    logic pol;
    logic any;
  } bank_wr_t;

  typedef struct packed {
    logic [PIN_W-1:0] din;
    logic [PIN_W-1:0] dir;
    logic [PIN_W-1:0] oe;
    logic [PIN_W-1:0] msk;
    logic [PIN_W-1:0] sts;
    logic [PIN_W-1:0] typ;
    logic [PIN_W-1:0] pol;
    logic [PIN_W-1:0] any;
  } bank_rd_t;

  function automatic logic [PIN_W-1:0] pin_mask(input int n);
    if (n >= PIN_W) return '1;
    return (PIN_W'(1) << n) - PIN_W'(1);
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync
  import pinbank_pkg::*;
#(
  parameter logic [PIN_W-1:0] VMASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pad_in,
  output logic [PIN_W-1:0] lvl,
  output logic [PIN_W-1:0] lvl_prev
);

  logic [PIN_W-1:0] meta_q, lvl_q, prev_q;
  logic [PIN_W-1:0] meta_d;

  always_comb begin
    meta_d = pad_in & VMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl      = lvl_q;
  assign lvl_prev = prev_q;

endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter logic [PIN_W-1:0] VMASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] lvl,
  input  logic [PIN_W-1:0] lvl_prev,
  input  logic [PIN_W-1:0] typ,
  input  logic [PIN_W-1:0] pol,
  input  logic [PIN_W-1:0] any,
  input  logic             wr_ien,
  input  logic             wr_idis,
  input  logic             wr_sts,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] sts,
  output logic [PIN_W-1:0] msk,
  output logic             irq_b
);

  logic [PIN_W-1:0] sts_q, sts_d, msk_q, msk_d;
  logic [PIN_W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr;
  logic             msk_en;

  always_comb begin
    rise     = lvl & ~lvl_prev;
    fall     = ~lvl & lvl_prev;
    edge_hit = (any & (rise | fall)) | (~any & ((pol & rise) | (~pol & fall)));
    lvl_hit  = (pol & lvl) | (~pol & ~lvl);
    hit      = ((typ & edge_hit) | (~typ & lvl_hit)) & VMASK;
    clr      = wr_sts ? wdata : '0;
    // a fresh detection outranks a clear in the same cycle
    sts_d    = ((sts_q & ~clr) | hit) & VMASK;
  end

  always_comb begin
    msk_en = wr_ien | wr_idis;
    msk_d  = msk_q;
    if (wr_ien)  msk_d = msk_d & ~wdata;
    if (wr_idis) msk_d = msk_d | wdata;
    msk_d  = msk_d & VMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= VMASK;
    end else begin
      sts_q <= sts_d;
      if (msk_en) msk_q <= msk_d;
    end
  end

  assign sts   = sts_q;
  assign msk   = msk_q;
  assign irq_b = |(sts_q & ~msk_q);

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
#(
  parameter logic [PIN_W-1:0] VMASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bank_wr_t         wr,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pad_in,
  output logic [PIN_W-1:0] pad_out,
  output logic [PIN_W-1:0] pad_oe,
  output bank_rd_t         rd,
  output logic             irq_b
);

  logic [PIN_W-1:0] out_q, out_d;
  logic [PIN_W-1:0] dir_q, oe_q, typ_q, pol_q, any_q;
  logic [PIN_W-1:0] cfg_d;
  logic             out_en;
  logic [PIN_W-1:0] lvl, lvl_prev, sts, msk;

  // half-bank masked update: a clear mask bit passes the data bit
  always_comb begin
    out_en = wr.lo | wr.hi;
    out_d  = out_q;
    for (int i = 0; i < HALF_W; i++) begin
      if (wr.lo && !wdata[HALF_W+i]) out_d[i]        = wdata[i];
      if (wr.hi && !wdata[HALF_W+i]) out_d[HALF_W+i] = wdata[i];
    end
    out_d = out_d & VMASK;
  end

  always_comb begin
    cfg_d = wdata & VMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      oe_q  <= '0;
      typ_q <= '0;
      pol_q <= '0;
      any_q <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      if (wr.dir) dir_q <= cfg_d;
      if (wr.oe)  oe_q  <= cfg_d;
      if (wr.typ) typ_q <= cfg_d;
      if (wr.pol) pol_q <= cfg_d;
      if (wr.any) any_q <= cfg_d;
    end
  end

  pinbank_sync #(.VMASK(VMASK)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  pinbank_irq #(.VMASK(VMASK)) i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .lvl_prev (lvl_prev),
    .typ      (typ_q),
    .pol      (pol_q),
    .any      (any_q),
    .wr_ien   (wr.ien),
    .wr_idis  (wr.idis),
    .wr_sts   (wr.sts),
    .wdata    (wdata),
    .sts      (sts),
    .msk      (msk),
    .irq_b    (irq_b)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q & oe_q;

  assign rd.din = lvl;
  assign rd.dir = dir_q;
  assign rd.oe  = oe_q;
  assign rd.msk = msk;
  assign rd.sts = sts;
  assign rd.typ = typ_q;
  assign rd.pol = pol_q;
  assign rd.any = any_q;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int                            NUM_BANKS = 4,
  parameter logic [NUM_BANKS*FIELD_W-1:0]  BANK_PINS = {6'd32, 6'd32, 6'd22, 6'd32},
  parameter int                            ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [PIN_W-1:0]           reg_wdata,
  input  logic                       reg_we,
  output logic [PIN_W-1:0]           reg_rdata,
  input  logic [NUM_BANKS*PIN_W-1:0] pad_in,
  output logic [NUM_BANKS*PIN_W-1:0] pad_out,
  output logic [NUM_BANKS*PIN_W-1:0] pad_oe,
  output logic                       irq
);

  localparam int ALL_W = NUM_BANKS * PIN_W;

  logic [ADDR_W-1:0]    aw;
  bank_rd_t             rd_arr [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_vec;

  assign aw = {reg_addr[ADDR_W-1:2], 2'b00};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int                NPINS = int'(BANK_PINS[b*FIELD_W +: FIELD_W]);
    localparam logic [PIN_W-1:0]  VM    = pin_mask(NPINS);
    localparam int                CB    = CTRL_BASE + CTRL_STRIDE * b;

    bank_wr_t wr_b;
    bank_rd_t rd_b;

    assign wr_b.lo   = reg_we && (aw == ADDR_W'(MW_STRIDE * b));
    assign wr_b.hi   = reg_we && (aw == ADDR_W'(MW_STRIDE * b + 4));
    assign wr_b.dir  = reg_we && (aw == ADDR_W'(CB + OFS_DIR));
    assign wr_b.oe   = reg_we && (aw == ADDR_W'(CB + OFS_OE));
    assign wr_b.ien  = reg_we && (aw == ADDR_W'(CB + OFS_IEN));
    assign wr_b.idis = reg_we && (aw == ADDR_W'(CB + OFS_IDIS));
    assign wr_b.sts  = reg_we && (aw == ADDR_W'(CB + OFS_STS));
    assign wr_b.typ  = reg_we && (aw == ADDR_W'(CB + OFS_TYP));
    assign wr_b.pol  = reg_we && (aw == ADDR_W'(CB + OFS_POL));
    assign wr_b.any  = reg_we && (aw == ADDR_W'(CB + OFS_ANY));

    pinbank_bank #(.VMASK(VM)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_b),
      .wdata   (reg_wdata),
      .pad_in  (pad_in[b*PIN_W +: PIN_W]),
      .pad_out (pad_out[b*PIN_W +: PIN_W]),
      .pad_oe  (pad_oe[b*PIN_W +: PIN_W]),
      .rd      (rd_b),
      .irq_b   (irq_vec[b])
    );

    assign rd_arr[b] = rd_b;
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (aw == ADDR_W'(IN_BASE + IN_STRIDE * b))                  reg_rdata = rd_arr[b].din;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_DIR))   reg_rdata = rd_arr[b].dir;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_OE))    reg_rdata = rd_arr[b].oe;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_MSK))   reg_rdata = rd_arr[b].msk;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_STS))   reg_rdata = rd_arr[b].sts;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_TYP))   reg_rdata = rd_arr[b].typ;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_POL))   reg_rdata = rd_arr[b].pol;
      if (aw == ADDR_W'(CTRL_BASE + CTRL_STRIDE * b + OFS_ANY))   reg_rdata = rd_arr[b].any;
    end
  end

  assign irq = |irq_vec;

  logic [ALL_W-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [31:0]                reg_wdata,
  input logic                       reg_we,
  input logic [31:0]                reg_rdata,
  input logic [NUM_BANKS*32-1:0]    pad_out,
  input logic [NUM_BANKS*32-1:0]    pad_oe,
  input logic                       irq
);

  // R1: held in reset the block drives nothing and requests nothing
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!irq && pad_oe == '0 && pad_out == '0));

  // R2: without a write strobe no output level moves
  assert_out_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(pad_out));

  // R2: a low-half write with every mask bit set changes nothing
  assert_full_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && reg_wdata[31:16] == 16'hFFFF) |=> $stable(pad_out));

  // R4: drive enables only move after a write
  assert_oe_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(pad_oe));

  // R12: the masked-write window reads back as zero
  assert_wo_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(NUM_BANKS * 8)) |-> (reg_rdata == '0));

endmodule

bind pinbank_ctrl pinbank_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_pinbank_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq)
);

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;

  localparam int NB = 4;

  logic           clk;
  logic           rst_n;
  logic [11:0]    reg_addr;
  logic [31:0]    reg_wdata;
  logic           reg_we;
  logic [31:0]    reg_rdata;
  logic [127:0]   pad_in;
  logic [127:0]   pad_out;
  logic [127:0]   pad_oe;
  logic           irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 0;
  bit live     = 0;

  pinbank_ctrl i_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference state, one entry per bank
  logic [31:0] vm [NB];
  logic [31:0] m_out[NB], m_dir[NB], m_oe[NB], m_msk[NB], m_sts[NB];
  logic [31:0] m_typ[NB], m_pol[NB], m_any[NB];
  logic [31:0] m_s1[NB], m_s2[NB], m_s3[NB];

  initial begin
    vm[0] = 32'hFFFF_FFFF; vm[1] = 32'h003F_FFFF;
    vm[2] = 32'hFFFF_FFFF; vm[3] = 32'hFFFF_FFFF;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_out[b] <= 0; m_dir[b] <= 0; m_oe[b] <= 0; m_msk[b] <= vm[b];
        m_sts[b] <= 0; m_typ[b] <= 0; m_pol[b] <= 0; m_any[b] <= 0;
        m_s1[b] <= 0; m_s2[b] <= 0; m_s3[b] <= 0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin : upd
        int          a, cb;
        logic [31:0] nout, nmsk, clr, hit;
        a    = {20'd0, reg_addr[11:2], 2'b00};
        cb   = 'h200 + 'h40 * b;
        nout = m_out[b];
        nmsk = m_msk[b];
        clr  = 0;
        for (int i = 0; i < 32; i++) begin
          if (m_typ[b][i]) begin
            if (m_any[b][i])      hit[i] = m_s2[b][i] != m_s3[b][i];
            else if (m_pol[b][i]) hit[i] = m_s2[b][i] && !m_s3[b][i];
            else                  hit[i] = !m_s2[b][i] && m_s3[b][i];
          end else begin
            hit[i] = m_s2[b][i] == m_pol[b][i];
          end
        end
        hit = hit & vm[b];
        if (reg_we) begin
          for (int i = 0; i < 16; i++) begin
            if (a == 8 * b     && !reg_wdata[16+i]) nout[i]    = reg_wdata[i];
            if (a == 8 * b + 4 && !reg_wdata[16+i]) nout[16+i] = reg_wdata[i];
          end
          if (a == cb + 'h04) m_dir[b] <= reg_wdata & vm[b];
          if (a == cb + 'h08) m_oe[b]  <= reg_wdata & vm[b];
          if (a == cb + 'h10) nmsk = nmsk & ~reg_wdata;
          if (a == cb + 'h14) nmsk = nmsk | reg_wdata;
          if (a == cb + 'h18) clr = reg_wdata;
          if (a == cb + 'h1C) m_typ[b] <= reg_wdata & vm[b];
          if (a == cb + 'h20) m_pol[b] <= reg_wdata & vm[b];
          if (a == cb + 'h24) m_any[b] <= reg_wdata & vm[b];
        end
        m_out[b] <= nout & vm[b];
        m_msk[b] <= nmsk & vm[b];
        m_sts[b] <= ((m_sts[b] & ~clr) | hit) & vm[b];
        m_s1[b]  <= pad_in[b*32 +: 32] & vm[b];
        m_s2[b]  <= m_s1[b];
        m_s3[b]  <= m_s2[b];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] addr);
    int a;
    a = {20'd0, addr[11:2], 2'b00};
    exp_rd = 0;
    for (int b = 0; b < NB; b++) begin
      if (a == 'h60 + 4 * b)            exp_rd = m_s2[b];
      if (a == 'h200 + 'h40 * b + 'h04) exp_rd = m_dir[b];
      if (a == 'h200 + 'h40 * b + 'h08) exp_rd = m_oe[b];
      if (a == 'h200 + 'h40 * b + 'h0C) exp_rd = m_msk[b];
      if (a == 'h200 + 'h40 * b + 'h18) exp_rd = m_sts[b];
      if (a == 'h200 + 'h40 * b + 'h1C) exp_rd = m_typ[b];
      if (a == 'h200 + 'h40 * b + 'h20) exp_rd = m_pol[b];
      if (a == 'h200 + 'h40 * b + 'h24) exp_rd = m_any[b];
    end
  endfunction

  task automatic chk(input logic [127:0] got, input logic [127:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the edge
  always @(posedge clk) begin
    #2;
    if (live && rst_n) begin
      logic [127:0] eo, eoe;
      logic         ei;
      ei = 0;
      for (int b = 0; b < NB; b++) begin
        eo[b*32 +: 32]  = m_out[b];
        eoe[b*32 +: 32] = m_dir[b] & m_oe[b];
        ei = ei | (|(m_sts[b] & ~m_msk[b]));
      end
      chk(pad_out, eo, "R2/R3 pad_out");
      chk(pad_oe, eoe, "R4 pad_oe");
      chk({127'd0, irq}, {127'd0, ei}, "R11 irq");
      chk({96'd0, reg_rdata}, {96'd0, exp_rd(reg_addr)}, "R5/R12 reg_rdata");
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    #1;
    chk({96'd0, reg_rdata}, {96'd0, e}, tag);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = 0; reg_wdata = 0; reg_we = 0; pad_in = 0;
    ticks(3);
    chk(pad_oe, 0, "R1 pad_oe in reset");
    chk(pad_out, 0, "R1 pad_out in reset");
    chk({127'd0, irq}, 0, "R1 irq in reset");
    rst_n = 1'b1;
    live  = 1'b1;
    ticks(1);
    rd_chk(12'h20C, 32'hFFFF_FFFF, "R1 bank0 mask after reset");
    rd_chk(12'h24C, 32'h003F_FFFF, "R6 bank1 mask after reset");
    rd_chk(12'h204, 32'h0, "R1 bank0 direction after reset");

    // R4 direction and enable
    wr(12'h204, 32'hFFFF_FFFF);
    wr(12'h208, 32'h0000_FFFF);
    chk(pad_oe[31:0], 32'h0000_FFFF, "R4 dir and oe combine");
    rd_chk(12'h204, 32'hFFFF_FFFF, "R12 direction readback");

    // R2 low-half masked writes
    wr(12'h000, 32'h00FF_A5A5);
    chk(pad_out[15:0], 16'hA500, "R2 upper pins pass, lower masked");
    wr(12'h000, 32'hFF00_00FF);
    chk(pad_out[15:0], 16'hA5FF, "R2 lower pins pass, upper masked");
    wr(12'h000, 32'hFFFF_0000);
    chk(pad_out[15:0], 16'hA5FF, "R2 full mask keeps levels");

    // R3 high half
    wr(12'h004, 32'h0000_1234);
    chk(pad_out[31:0], 32'h1234_A5FF, "R3 high half write");
    rd_chk(12'h004, 32'h0, "R12 masked-write address reads zero");

    // R6 short bank
    wr(12'h244, 32'hFFFF_FFFF);
    rd_chk(12'h244, 32'h003F_FFFF, "R6 missing pins read zero");
    wr(12'h00C, 32'h0000_FFFF);
    chk(pad_out[63:32], 32'h003F_0000, "R6 missing pins ignore writes");

    // R5 input readback latency
    @(negedge clk);
    pad_in[95:64] = 32'hDEAD_BEEF;
    reg_addr = 12'h068;
    @(negedge clk);
    chk({96'd0, reg_rdata}, 0, "R5 one edge after change");
    @(negedge clk);
    chk({96'd0, reg_rdata}, 32'hDEAD_BEEF, "R5 two edges after change");

    // R8 edge detection on bank 3
    wr(12'h2DC, 32'hFFFF_FFFF);
    wr(12'h2D8, 32'hFFFF_FFFF);
    wr(12'h2E0, 32'h0000_0011);
    wr(12'h2E4, 32'h0000_0004);
    wr(12'h2D0, 32'h0000_0007);
    rd_chk(12'h2D8, 32'h0, "R10 status cleared");
    rd_chk(12'h2CC, 32'hFFFF_FFF8, "R7 enable clears mask bits");
    chk({127'd0, irq}, 0, "R11 no request yet");
    pad_in[96] = 1'b1;
    ticks(3);
    rd_chk(12'h2D8, 32'h1, "R8 rising edge");
    chk({127'd0, irq}, 1, "R11 unmasked status raises irq");
    wr(12'h2D8, 32'h1);
    rd_chk(12'h2D8, 32'h0, "R10 write one clears");
    chk({127'd0, irq}, 0, "R11 irq drops after clear");
    pad_in[97] = 1'b1;
    ticks(3);
    rd_chk(12'h2D8, 32'h0, "R8 falling polarity ignores rise");
    pad_in[97] = 1'b0;
    ticks(3);
    rd_chk(12'h2D8, 32'h2, "R8 falling edge");
    pad_in[98] = 1'b1;
    ticks(3);
    rd_chk(12'h2D8, 32'h6, "R8 any-edge rise");
    wr(12'h2D8, 32'h6);
    pad_in[98] = 1'b0;
    ticks(3);
    rd_chk(12'h2D8, 32'h4, "R8 any-edge fall");

    // R7 mask all
    wr(12'h2D4, 32'hFFFF_FFFF);
    rd_chk(12'h2CC, 32'hFFFF_FFFF, "R7 disable all");
    chk({127'd0, irq}, 0, "R7 masked status gives no irq");
    wr(12'h2D0, 32'h4);
    chk({127'd0, irq}, 1, "R11 unmask pending status");
    wr(12'h2D8, 32'h4);
    wr(12'h2D4, 32'hFFFF_FFFF);

    // R9 level mode with R10 set-over-clear
    wr(12'h2DC, 32'hFFFF_FFEF);
    wr(12'h2D0, 32'h10);
    rd_chk(12'h2D8, 32'h0, "R9 level not matched");
    pad_in[100] = 1'b1;
    ticks(3);
    rd_chk(12'h2D8, 32'h10, "R9 level high sets status");
    wr(12'h2D8, 32'h10);
    rd_chk(12'h2D8, 32'h10, "R10 detection outranks clear");
    pad_in[100] = 1'b0;
    ticks(3);
    wr(12'h2D8, 32'h10);
    rd_chk(12'h2D8, 32'h0, "R9 cleared after level drops");
    chk({127'd0, irq}, 0, "R11 irq idle at end");
    rd_chk(12'h2D0, 32'h0, "R12 enable address reads zero");
    rd_chk(12'h2E0, 32'h11, "R12 polarity readback");

    ticks(2);
    live = 1'b0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule